// File: doc/BRIEF.md
# BCD Start/Stop Chronometer (MM:SS:T)

This block is a stopwatch that keeps elapsed time as five BCD digits: two for minutes, two for seconds and one for tenths of a second. A shared 10 Hz enable, one clock cycle wide, sets the pace. A one-cycle start pulse arms counting and a one-cycle stop pulse freezes it. The pulses may come from debounced push-buttons or from a supervising state machine, for example one that times how long a tank takes to drain.

The design has two parts. A small control unit holds the running state and a sticky overflow flag. A cascade of modulo-10 and modulo-6 digit counters holds the time. Each digit advances only when every digit below it is at its maximum in the same cycle. When the display already shows 59:59.9 and another tick arrives, the count holds and the overflow flag rises. Only reset clears the flag and the count.

Top module: `stopwatch_bcd`

## Requirements
- R1: The synchronous active-high reset sets all five digits to 0 (00:00.0), sets running_o to 0 and sets overflow_o to 0.
- R2: A start pulse with no stop pulse sets running_o after that clock edge. A stop pulse clears running_o after that edge. While running_o is 0, the time is held.
- R3: When start and stop are high in the same cycle, stop takes priority and running_o is 0 afterwards.
- R4: The tenths digit advances by exactly one at an edge where both tick_10hz and running_o are high. Without both, no digit changes.
- R5: The tenths digit counts 0 to 9. At a tick where it shows 9, it returns to 0 and the seconds-units digit advances.
- R6: The seconds-units digit counts modulo 10 and the seconds-tens digit counts modulo 6. So 00:59.9 followed by one tick becomes 01:00.0.
- R7: The minutes-units digit counts modulo 10 and the minutes-tens digit counts modulo 6, so the largest time shown is 59:59.9.
- R8: A tick while running at 59:59.9 sets overflow_o and leaves the digits at 59:59.9. overflow_o then stays 1 until reset, whatever start, stop or tick do.
- R9: A start after a stop resumes counting from the held value and does not clear it.
- R10: Every digit always stays below its modulus (10 or 6), so the outputs are always valid BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_10hz | input | 1 | One-cycle enable at 10 Hz |
| start_pulse | input | 1 | One-cycle start request |
| stop_pulse | input | 1 | One-cycle stop request (has priority over start) |
| tenths_o | output | 4 | Tenths of a second, BCD |
| sec_ones_o | output | 4 | Seconds units, BCD |
| sec_tens_o | output | 4 | Seconds tens, BCD 0 to 5 |
| min_ones_o | output | 4 | Minutes units, BCD |
| min_tens_o | output | 4 | Minutes tens, BCD 0 to 5 |
| running_o | output | 1 | Counting is enabled |
| overflow_o | output | 1 | Sticky terminal-count flag |

## Verification
Some properties are checked on every cycle:
- each digit stays inside its range;
- a digit holds its value unless stepped, and wraps to 0 when stepped at its maximum;
- stop has priority over start;
- the overflow flag is sticky, has a legal cause, and is set only while the count sits at its maximum.

The chained behaviours need the bench scenarios. These are:
- the carries at 59.9 and at 59:59.9;
- a resume that keeps the held value;
- a count that stays frozen across ticks after a stop or after overflow.

The bench checks these against a behavioural model that counts elapsed tenths as a single integer.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int NUM_DIGITS = 5;
  localparam int DIGIT_W    = 4;

  // Digit order, least significant first:
  // tenths, seconds units, seconds tens, minutes units, minutes tens
  function automatic int digit_modulus(input int idx);
    case (idx)
      2, 4:    return 6;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/stopwatch_digit.sv
module stopwatch_digit #(
  parameter int MODULUS = 10,
  parameter int WIDTH   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  output logic [WIDTH-1:0] value,
  output logic             at_max
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

  assign at_max = (value == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (step_en) begin
      value <= at_max ? '0 : value + 1'b1;
    end
  end

  assert_digit_range_R10: assert property (@(posedge clk) disable iff (rst)
    value <= TOP);

  assert_digit_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && at_max) |=> (value == '0));

  assert_digit_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(value));
endmodule

// File: rtl/stopwatch_ctrl.sv
module stopwatch_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start_req,
  input  logic stop_req,
  input  logic count_full,
  output logic running,
  output logic overflow,
  output logic advance
);
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (stop_req) begin
      running <= 1'b0;
    end else if (start_req) begin
      running <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow <= 1'b0;
    end else if (tick && running && count_full) begin
      overflow <= 1'b1;
    end
  end

  assign advance = tick && running && !count_full;

  assert_stop_wins_R3: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !running);

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (rst)
    (start_req && !stop_req) |=> running);

  assert_sticky_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_overflow_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(tick && running && count_full));
endmodule

// File: rtl/stopwatch_bcd.sv
module stopwatch_bcd
  import stopwatch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_10hz,
  input  logic       start_pulse,
  input  logic       stop_pulse,
  output logic [3:0] tenths_o,
  output logic [3:0] sec_ones_o,
  output logic [3:0] sec_tens_o,
  output logic [3:0] min_ones_o,
  output logic [3:0] min_tens_o,
  output logic       running_o,
  output logic       overflow_o
);
  logic [DIGIT_W-1:0] digit_val [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] digit_top;
  logic [NUM_DIGITS:0]   lower_full;
  logic                  advance;
  logic                  count_full;

  assign lower_full[0] = 1'b1;
  assign count_full    = lower_full[NUM_DIGITS];

  stopwatch_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_10hz),
    .start_req  (start_pulse),
    .stop_req   (stop_pulse),
    .count_full (count_full),
    .running    (running_o),
    .overflow   (overflow_o),
    .advance    (advance)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    assign lower_full[i+1] = lower_full[i] && digit_top[i];

    stopwatch_digit #(
      .MODULUS (digit_modulus(i)),
      .WIDTH   (DIGIT_W)
    ) u_digit (
      .clk     (clk),
      .rst     (rst),
      .step_en (advance && lower_full[i]),
      .value   (digit_val[i]),
      .at_max  (digit_top[i])
    );
  end

  assign tenths_o   = digit_val[0];
  assign sec_ones_o = digit_val[1];
  assign sec_tens_o = digit_val[2];
  assign min_ones_o = digit_val[3];
  assign min_tens_o = digit_val[4];

  assert_overflow_at_max_R8: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> (tenths_o == 4'd9 && sec_ones_o == 4'd9 && sec_tens_o == 4'd5
                    && min_ones_o == 4'd9 && min_tens_o == 4'd5));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !running_o |=> $stable({min_tens_o, min_ones_o, sec_tens_o, sec_ones_o, tenths_o}));
endmodule

// File: tb/stopwatch_bcd_tb.sv
module stopwatch_bcd_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, st = 1'b0, sp = 1'b0;
  logic [3:0] t_o, so_o, st_o, mo_o, mt_o;
  logic run_o, ovf_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  int m_cnt = 0;
  bit m_run = 1'b0;
  bit m_ovf = 1'b0;

  always #2 clk = ~clk;

  stopwatch_bcd u_dut (
    .clk(clk), .rst(rst), .tick_10hz(tick), .start_pulse(st), .stop_pulse(sp),
    .tenths_o(t_o), .sec_ones_o(so_o), .sec_tens_o(st_o),
    .min_ones_o(mo_o), .min_tens_o(mt_o), .running_o(run_o), .overflow_o(ovf_o)
  );

  // Reference: elapsed time as one integer count of tenths
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_run = 1'b0; m_ovf = 1'b0;
    end else begin
      if (tick && m_run) begin
        if (m_cnt == 35999) m_ovf = 1'b1;
        else m_cnt = m_cnt + 1;
      end
      if (sp) m_run = 1'b0;
      else if (st) m_run = 1'b1;
    end
  end

  function automatic logic [19:0] to_bcd(input int c);
    int sec, mins;
    sec  = (c / 10) % 60;
    mins = c / 600;
    return {4'(mins / 10), 4'(mins % 10), 4'(sec / 10), 4'(sec % 10), 4'(c % 10)};
  endfunction

  function automatic logic [19:0] shown();
    return {mt_o, mo_o, st_o, so_o, t_o};
  endfunction

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R5 time vs model", shown(), to_bcd(m_cnt));
      chk("R2 running vs model", 20'(run_o), 20'(m_run));
      chk("R8 overflow vs model", 20'(ovf_o), 20'(m_ovf));
    end
  end

  task automatic pulse(input bit t, input bit a, input bit b);
    @(negedge clk); #1 tick = t; st = a; sp = b;
    @(negedge clk); #1 tick = 1'b0; st = 1'b0; sp = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); #1 tick = 1'b1;
    for (int k = 1; k < n; k++) @(negedge clk);
    @(negedge clk); #1 tick = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset time", shown(), 20'h0);
    chk("R1 reset running", 20'(run_o), 20'h0);
    chk("R1 reset overflow", 20'(ovf_o), 20'h0);
    #1 rst = 1'b0;
    cmp_on = 1'b1;

    pulse(1, 0, 0);
    chk("R4 tick while stopped", shown(), 20'h0);
    pulse(0, 1, 1);
    chk("R3 stop wins", 20'(run_o), 20'h0);
    pulse(0, 1, 0);
    chk("R2 start sets running", 20'(run_o), 20'h1);
    run_ticks(1);
    chk("R4 one tick", shown(), to_bcd(1));
    pulse(0, 0, 0);
    chk("R4 no tick no change", shown(), to_bcd(1));
    run_ticks(8);
    chk("R5 nine tenths", shown(), 20'h00009);
    run_ticks(1);
    chk("R5 tenths carry", shown(), 20'h00010);
    run_ticks(590);
    chk("R6 seconds to minute", shown(), 20'h01000);
    pulse(0, 0, 1);
    chk("R2 stop clears running", 20'(run_o), 20'h0);
    run_ticks(20);
    chk("R2 held while stopped", shown(), 20'h01000);
    pulse(0, 1, 0);
    run_ticks(1);
    chk("R9 resume from held", shown(), 20'h01001);
    run_ticks(35999 - 601);
    chk("R7 maximum time", shown(), 20'h59599);
    chk("R7 no overflow yet", 20'(ovf_o), 20'h0);
    run_ticks(1);
    chk("R8 overflow raised", 20'(ovf_o), 20'h1);
    chk("R8 count held", shown(), 20'h59599);
    pulse(0, 0, 1);
    pulse(0, 1, 0);
    run_ticks(5);
    chk("R8 overflow sticky", 20'(ovf_o), 20'h1);
    chk("R10 digits in range", 20'((t_o < 10) && (so_o < 10) && (st_o < 6)
                                   && (mo_o < 10) && (mt_o < 6)), 20'h1);
    @(negedge clk); #1 rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears all", {shown()}, 20'h0);
    chk("R1 reset clears overflow", 20'(ovf_o), 20'h0);
    #1 rst = 1'b0;
    repeat (2) @(negedge clk);
    cmp_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule